// File: doc/BRIEF.md
# Soft Power Event Latch and Off-Delay Timer

This block sits in the always-on power domain. It watches four wake-related inputs: two serial receive-data lines, an active-low ring indicator and an active-low push button. Each input passes through a two-flop synchronizer. A falling edge on any of them sets a sticky bit in a status register. Reading that register returns the captured bits and clears them in the same clock.

The two receive lines and the ring indicator can each be routed to a power-on request through their own enable bit. The button bit is for reporting only and never raises the power-on request.

The button can also start a programmable off-delay timer, but only when both the off-enable and the off-delay-select bits are set. The timer counts an external millisecond tick in steps of 500 ms. When it expires it raises a one-clock power-off request and returns to idle. Software reaches three byte registers through a simple index, data and strobe port.

Top module: `wake_event_ctl`

## Requirements
- R1: A falling edge on `rxA` sets status bit 0 and a falling edge on `rxB` sets status bit 1. The status register is at index 0xB7.
- R2: A falling edge on `ringN` sets status bit 3. `pwrOnReq` is high while any of the following holds:
  - status bit 0 is set and control bit 0 is set;
  - status bit 1 is set and control bit 1 is set;
  - status bit 3 is set and control bit 2 is set.
- R3: A falling edge on `buttonN` sets status bit 2. That bit never affects `pwrOnReq`.
- R4: A read of index 0xB7 returns status bits 3:0, with bits 7:4 as zero, on `regRdData` one clock after the strobe. The same edge clears the status bits.
- R5: An event that is detected in the same clock as a status read stays latched, and it is returned by the next read.
- R6: The delay register at index 0xB8 stores write bits 5:0 and reads back with bits 7:6 as zero. It resets to 0x00.
- R7: The control register is at index 0xB9, with bit 4 as off-enable and bit 5 as off-delay-select. The timer starts on a button press only when both bits are set.
- R8: Once started, the timer raises `pwrOffReq` for exactly one clock on the `msTick` pulse that completes (delay+1)×MS_PER_STEP+1 ticks. A button press while the timer runs does not restart it.
- R9: The control register stores bits 0,1,2,4,5 and reads bits 3,6,7 as zero. It resets to 0x00. Reads of any other index return 0x00, and writes to index 0xB7 have no effect.
- R10: A rising edge on any event input sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regIdx | input | 8 | Register index |
| regWrData | input | 8 | Write data |
| regWr | input | 1 | Write strobe, one clock |
| regRd | input | 1 | Read strobe, one clock |
| regRdData | output | 8 | Read data, valid one clock after `regRd` |
| rxA | input | 1 | First serial receive-data line |
| rxB | input | 1 | Second serial receive-data line |
| ringN | input | 1 | Ring indicator, active low |
| buttonN | input | 1 | Push button, active low |
| msTick | input | 1 | One-clock pulse every millisecond |
| pwrOnReq | output | 1 | Power-on request (level) |
| pwrOffReq | output | 1 | Power-off request (one-clock pulse) |

## Verification
The assertions check the following on every cycle:
- a status read clears the register unless an edge arrives at the same time;
- a coincident edge survives the clear;
- reserved read-back bits are zero;
- the power-off pulse lasts one clock;
- the timer stays idle unless both off bits are set;
- the power-on request is low whenever no wake-capable bit is set.

Only the bench scenarios can show the exact tick count to expiry for a given delay setting. The same applies to the refusal to restart on a second press, the absence of capture on rising edges, and the read-to-event race at its exact cycle. These scenarios are compared against a behavioural model on every clock.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int NUM_EV  = 4;
  localparam int EV_RXA  = 0;
  localparam int EV_RXB  = 1;
  localparam int EV_BTN  = 2;
  localparam int EV_RING = 3;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_DELAY  = 2'd2,
    RD_CTRL   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clrStatus;
    logic   rdEn;
    rdSel_e rdSel;
    logic   wrDelay;
    logic   wrCtrl;
    logic   cntLoad;
    logic   cntDec;
  } ctlStrobe_t;

endpackage

// File: rtl/wake_ctl.sv
module wake_ctl
  import wake_pkg::*;
#(
  parameter logic [7:0] STATUS_IDX = 8'hB7,
  parameter logic [7:0] DELAY_IDX  = 8'hB8,
  parameter logic [7:0] CTRL_IDX   = 8'hB9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regIdx,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       btnEvt,
  input  logic       offEn,
  input  logic       offSel,
  input  logic       msTick,
  input  logic       cntLast,
  output ctlStrobe_t strb,
  output logic       pwrOffReq
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tmrState_e;

  tmrState_e state;
  logic      hitSts;
  logic      hitDly;
  logic      hitCtrl;
  logic      startOk;
  logic      expireNow;

  assign hitSts  = (regIdx == STATUS_IDX);
  assign hitDly  = (regIdx == DELAY_IDX);
  assign hitCtrl = (regIdx == CTRL_IDX);

  assign startOk   = (state == ST_IDLE) && btnEvt && offEn && offSel;
  assign expireNow = (state == ST_RUN) && msTick && cntLast;

  always_comb begin
    strb           = '0;
    strb.rdEn      = regRd;
    strb.clrStatus = regRd && hitSts;
    strb.wrDelay   = regWr && hitDly;
    strb.wrCtrl    = regWr && hitCtrl;
    strb.cntLoad   = startOk;
    strb.cntDec    = (state == ST_RUN) && msTick && !cntLast;
    if (hitSts)       strb.rdSel = RD_STATUS;
    else if (hitDly)  strb.rdSel = RD_DELAY;
    else if (hitCtrl) strb.rdSel = RD_CTRL;
    else              strb.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pwrOffReq <= 1'b0;
    end else begin
      pwrOffReq <= expireNow;
      case (state)
        ST_IDLE: if (startOk) state <= ST_RUN;
        ST_RUN:  if (expireNow) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_OFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |=> !pwrOffReq); // R8

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(offEn && offSel)) |=> (state == ST_IDLE)); // R7

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !msTick) |=> (state == ST_RUN)); // R8

endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
#(
  parameter int DLY_BITS    = 6,
  parameter int MS_PER_STEP = 500,
  parameter int SLACK_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EV-1:0] rawN,
  input  logic [7:0]        regWrData,
  input  ctlStrobe_t        strb,
  output logic [7:0]        regRdData,
  output logic              btnEvt,
  output logic              offEn,
  output logic              offSel,
  output logic              cntLast,
  output logic              pwrOnReq
);

  localparam int          MAX_TICKS = (1 << DLY_BITS) * MS_PER_STEP + SLACK_TICKS;
  localparam int          CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [7:0]  CTRL_MASK = 8'h37;

  logic [NUM_EV-1:0]   evtFall;
  logic [NUM_EV-1:0]   sts;
  logic [DLY_BITS-1:0] dlyReg;
  logic [7:0]          ctrlReg;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    loadVal;
  logic [NUM_EV-1:0]   wakeMask;

  for (genvar g = 0; g < NUM_EV; g++) begin : gSync
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= 3'b111;
      else       sh <= {sh[1:0], rawN[g]};
    end
    assign evtFall[g] = sh[2] & ~sh[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sts <= '0;
    else       sts <= (strb.clrStatus ? '0 : sts) | evtFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyReg  <= '0;
      ctrlReg <= '0;
    end else begin
      if (strb.wrDelay) dlyReg  <= regWrData[DLY_BITS-1:0];
      if (strb.wrCtrl)  ctrlReg <= regWrData & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_STATUS: regRdData <= {{(8-NUM_EV){1'b0}}, sts};
        RD_DELAY:  regRdData <= {{(8-DLY_BITS){1'b0}}, dlyReg};
        RD_CTRL:   regRdData <= ctrlReg;
        default:   regRdData <= '0;
      endcase
    end
  end

  assign loadVal = (CNT_W'(dlyReg) + CNT_W'(1)) * CNT_W'(MS_PER_STEP) + CNT_W'(SLACK_TICKS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.cntLoad) cnt <= loadVal;
    else if (strb.cntDec)  cnt <= cnt - CNT_W'(1);
  end

  assign cntLast = (cnt == CNT_W'(1));
  assign btnEvt  = evtFall[EV_BTN];
  assign offEn   = ctrlReg[4];
  assign offSel  = ctrlReg[5];

  always_comb begin
    wakeMask          = '0;
    wakeMask[EV_RXA]  = ctrlReg[0];
    wakeMask[EV_RXB]  = ctrlReg[1];
    wakeMask[EV_RING] = ctrlReg[2];
  end

  assign pwrOnReq = |(sts & wakeMask);

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && evtFall == '0) |=> (sts == '0)); // R4

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    evtFall[EV_RXA] |=> sts[EV_RXA]); // R5

  AST_STS_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == RD_STATUS) |=> (regRdData[7:4] == 4'h0)); // R4

  AST_DLY_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == RD_DELAY) |=> (regRdData[7:6] == 2'b00)); // R6

  AST_BTN_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!sts[EV_RXA] && !sts[EV_RXB] && !sts[EV_RING]) |-> !pwrOnReq); // R3

endmodule

// File: rtl/wake_event_ctl.sv
module wake_event_ctl
  import wake_pkg::*;
#(
  parameter int         DLY_BITS    = 6,
  parameter int         MS_PER_STEP = 500,
  parameter int         SLACK_TICKS = 1,
  parameter logic [7:0] STATUS_IDX  = 8'hB7,
  parameter logic [7:0] DELAY_IDX   = 8'hB8,
  parameter logic [7:0] CTRL_IDX    = 8'hB9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regIdx,
  input  logic [7:0] regWrData,
  input  logic       regWr,
  input  logic       regRd,
  output logic [7:0] regRdData,
  input  logic       rxA,
  input  logic       rxB,
  input  logic       ringN,
  input  logic       buttonN,
  input  logic       msTick,
  output logic       pwrOnReq,
  output logic       pwrOffReq
);

  ctlStrobe_t        strb;
  logic              btnEvt;
  logic              offEn;
  logic              offSel;
  logic              cntLast;
  logic [NUM_EV-1:0] rawN;

  always_comb begin
    rawN          = '1;
    rawN[EV_RXA]  = rxA;
    rawN[EV_RXB]  = rxB;
    rawN[EV_BTN]  = buttonN;
    rawN[EV_RING] = ringN;
  end

  wake_ctl #(
    .STATUS_IDX(STATUS_IDX), .DELAY_IDX(DELAY_IDX), .CTRL_IDX(CTRL_IDX)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .regWr(regWr), .regRd(regRd),
    .btnEvt(btnEvt), .offEn(offEn), .offSel(offSel), .msTick(msTick),
    .cntLast(cntLast), .strb(strb), .pwrOffReq(pwrOffReq)
  );

  wake_dp #(
    .DLY_BITS(DLY_BITS), .MS_PER_STEP(MS_PER_STEP), .SLACK_TICKS(SLACK_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawN(rawN), .regWrData(regWrData), .strb(strb),
    .regRdData(regRdData), .btnEvt(btnEvt), .offEn(offEn), .offSel(offSel),
    .cntLast(cntLast), .pwrOnReq(pwrOnReq)
  );

endmodule

// File: tb/wake_event_ctl_tb.sv
`timescale 1ns/1ps
module wake_event_ctl_tb;

  localparam int STEP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regIdx = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regRdData;
  logic       rxA = 1'b1, rxB = 1'b1, ringN = 1'b1, buttonN = 1'b1;
  logic       msTick = 1'b0;
  logic       pwrOnReq, pwrOffReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  wake_event_ctl #(.MS_PER_STEP(STEP)) u_dut (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData),
    .rxA(rxA), .rxB(rxB), .ringN(ringN), .buttonN(buttonN),
    .msTick(msTick), .pwrOnReq(pwrOnReq), .pwrOffReq(pwrOffReq)
  );

  // ---------------- behavioural reference model ----------------
  bit       hist[4][$];
  bit [3:0] mSts;
  bit [5:0] mDly;
  bit [7:0] mCtrl;
  bit [7:0] mRd;
  bit       mOff;
  bit       mRun;
  int       mLeft;
  int       tickPhase = 0;
  int       offPulses = 0;

  function automatic bit rawOf(int i);
    case (i)
      0: return rxA;
      1: return rxB;
      2: return buttonN;
      default: return ringN;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        hist[i].delete();
        repeat (3) hist[i].push_back(1'b1);
      end
      mSts = 0; mDly = 0; mCtrl = 0; mRd = 0; mOff = 0; mRun = 0; mLeft = 0;
    end else begin
      bit [3:0] fall;
      bit       stsRead;
      for (int i = 0; i < 4; i++) begin
        fall[i] = hist[i][2] && !hist[i][1];
        void'(hist[i].pop_back());
        hist[i].push_front(rawOf(i));
      end
      // timer, using configuration from before this edge
      mOff = 0;
      if (mRun) begin
        if (msTick) begin
          if (mLeft == 1) begin mOff = 1; mRun = 0; end
          else mLeft--;
        end
      end else if (fall[2] && mCtrl[4] && mCtrl[5]) begin
        mLeft = (int'(mDly) + 1) * STEP + 1;
        mRun  = 1;
      end
      stsRead = regRd && regIdx == 8'hB7;
      if (regRd) begin
        case (regIdx)
          8'hB7:   mRd = {4'h0, mSts};
          8'hB8:   mRd = {2'b00, mDly};
          8'hB9:   mRd = mCtrl;
          default: mRd = 8'h00;
        endcase
      end
      mSts = (stsRead ? 4'h0 : mSts) | fall;
      if (regWr && regIdx == 8'hB8) mDly = regWrData[5:0];
      if (regWr && regIdx == 8'hB9) mCtrl = regWrData & 8'h37;
    end
  end

  function automatic bit mPwrOn();
    return (mSts[0] && mCtrl[0]) || (mSts[1] && mCtrl[1]) || (mSts[3] && mCtrl[2]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and tick generation, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(regRdData == mRd, "R4/R6/R9 readback", regRdData, mRd);
      check(pwrOnReq == mPwrOn(), "R2/R3 pwrOnReq", pwrOnReq, mPwrOn());
      check(pwrOffReq == mOff, "R8 pwrOffReq", pwrOffReq, mOff);
      if (pwrOffReq) offPulses++;
    end
    tickPhase = (tickPhase + 1) % 3;
    msTick = (tickPhase == 0);
  end

  // ---------------- stimulus tasks ----------------
  task automatic regWrite(input logic [7:0] idx, input logic [7:0] data);
    @(negedge clk);
    regIdx = idx; regWrData = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] data);
    @(negedge clk);
    regIdx = idx; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    data = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int p0;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // reset state
    check(regRdData == 8'h00, "R4 reset rdData", regRdData, 0);
    check(pwrOnReq == 1'b0, "R2 reset pwrOnReq", pwrOnReq, 0);
    check(pwrOffReq == 1'b0, "R8 reset pwrOffReq", pwrOffReq, 0);
    regRead(8'hB8, d); check(d == 8'h00, "R6 delay reset", d, 0);
    regRead(8'hB9, d); check(d == 8'h00, "R9 ctrl reset", d, 0);

    // register masks and unmapped index
    regWrite(8'hB9, 8'hFF);
    regRead(8'hB9, d); check(d == 8'h37, "R9 ctrl mask", d, 8'h37);
    regWrite(8'hB8, 8'hFF);
    regRead(8'hB8, d); check(d == 8'h3F, "R6 delay mask", d, 8'h3F);
    regRead(8'h42, d); check(d == 8'h00, "R9 unmapped read", d, 0);
    regWrite(8'hB7, 8'h0F);
    regRead(8'hB7, d); check(d == 8'h00, "R9 status write ignored", d, 0);

    // R1 receive-line events with wake routing
    regWrite(8'hB9, 8'h01);
    rxA = 1'b0; idle(2); rxA = 1'b1; idle(4);
    check(pwrOnReq == 1'b1, "R2 wake from rxA", pwrOnReq, 1);
    regRead(8'hB7, d); check(d == 8'h01, "R1 rxA status", d, 1);
    check(pwrOnReq == 1'b0, "R4 wake drops after read", pwrOnReq, 0);
    rxB = 1'b0; idle(2); rxB = 1'b1; idle(4);
    check(pwrOnReq == 1'b0, "R2 rxB not routed", pwrOnReq, 0);
    regRead(8'hB7, d); check(d == 8'h02, "R1 rxB status", d, 2);
    regRead(8'hB7, d); check(d == 8'h00, "R4 cleared by read", d, 0);

    // R2 ring wake
    regWrite(8'hB9, 8'h04);
    ringN = 1'b0; idle(5); ringN = 1'b1; idle(2);
    check(pwrOnReq == 1'b1, "R2 ring wake", pwrOnReq, 1);
    regRead(8'hB7, d); check(d == 8'h08, "R2 ring status", d, 8);

    // R10 rising edge alone records nothing
    rxA = 1'b0; idle(5);
    regRead(8'hB7, d);
    rxA = 1'b1; idle(6);
    regRead(8'hB7, d); check(d == 8'h00, "R10 no capture on rise", d, 0);

    // R5 event arriving in the same clock as the status read
    @(negedge clk); rxB = 1'b0;
    @(negedge clk);
    @(negedge clk); regIdx = 8'hB7; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdData;
    check(d == 8'h00, "R5 coincident read", d, 0);
    rxB = 1'b1;
    regRead(8'hB7, d); check(d == 8'h02, "R5 event kept", d, 2);

    // R3 button, all wake enables on, timer disabled
    regWrite(8'hB9, 8'h17);
    p0 = offPulses;
    buttonN = 1'b0; idle(3); buttonN = 1'b1; idle(4);
    check(pwrOnReq == 1'b0, "R3 button no wake", pwrOnReq, 0);
    regRead(8'hB7, d); check(d == 8'h04, "R3 button status", d, 4);
    idle(150);
    check(offPulses == p0, "R7 no start without select", offPulses, p0);

    // R7/R8 timer run with delay 1, second press during run
    regWrite(8'hB8, 8'h01);
    regWrite(8'hB9, 8'h30);
    p0 = offPulses;
    buttonN = 1'b0; idle(3); buttonN = 1'b1;
    idle(10);
    buttonN = 1'b0; idle(3); buttonN = 1'b1;
    idle(120);
    check(offPulses == p0 + 1, "R8 one off pulse", offPulses, p0 + 1);

    // R8 longest setting
    regWrite(8'hB8, 8'h3F);
    p0 = offPulses;
    buttonN = 1'b0; idle(3); buttonN = 1'b1;
    idle(300);
    check(offPulses == p0, "R8 not expired early", offPulses, p0);
    idle(600);
    check(offPulses == p0 + 1, "R8 long delay expiry", offPulses, p0 + 1);
    regRead(8'hB7, d);

    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule